// File: doc/BRIEF.md
# Edge-Interval Bitcheck Sequencer

This block decides whether a demodulated serial stream looks like a valid transmitter signal. It starts when it receives a start pulse. It then waits through a fixed startup phase. After that it times the gap between successive edges of the synchronized demodulator bit, measured in ticks of an extended clock strobe. Each gap is one half-bit period of the incoming data. Each gap must fall inside a programmable window. A gap that is too short fails the check when its closing edge arrives. A gap that grows to the upper limit fails the check on that tick, without waiting for an edge.

When the required number of consecutive gaps have passed, the block enters receiving mode and stays there until a return-to-polling command. A failed check puts the block to sleep with its fail flag raised and the interval counter at zero. The block stays asleep until the next start pulse. The lower limit, the upper limit and the required count are captured when the start pulse is accepted.

Top module: `bchk_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (sleep), `pass_o` is 0, `fail_o` is 0 and `cnt_o` is 0. The mode encoding is 0 sleep, 1 startup, 2 bitcheck, 3 receiving.
- R2: A start pulse is accepted only in sleep. When accepted, it captures the limits and the required count, and the mode becomes startup on the next clock. A start pulse in any other mode has no effect.
- R3: Startup lasts exactly STARTUP_TICKS ticks. After the last of those ticks the mode is bitcheck and `cnt_o` is 0.
- R4: In bitcheck, an edge is a tick on which `dem_i` differs from its value at the previous tick. `cnt_o` rises by one on each tick without an edge and is set to 1 on each tick with an edge.
- R5: An edge that closes a gap while `cnt_o` is below the lower limit fails the check. On a fail the mode becomes sleep, `fail_o` becomes 1 and `cnt_o` becomes 0, all on the same clock.
- R6: A tick without an edge that would bring the count to the upper limit fails the check on that tick.
- R7: The first edge seen in bitcheck only starts timing. It is never judged against the lower limit and is not counted as a passing gap.
- R8: A gap closed by an edge with `cnt_o` at or above the lower limit passes. When the number of consecutive passing gaps equals the required count, the mode becomes receiving and `pass_o` becomes 1. A required count of 0 acts as 1.
- R9: Receiving mode holds until `poll_i` is asserted. Then the mode becomes sleep with both `pass_o` and `fail_o` at 0. `poll_i` has no effect in other modes.
- R10: A start pulse with the lower limit not below the upper limit fails at once. The mode stays sleep, `fail_o` is 1 and no startup takes place.
- R11: `fail_o` stays at 1 through sleep until a start pulse is accepted. It is cleared when a valid start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Extended-clock tick strobe, one cycle wide |
| dem_i | input | 1 | Synchronized demodulator bit |
| start_i | input | 1 | Enable/start pulse |
| lim_lo_i | input | LIM_W | Lower gap limit in ticks |
| lim_hi_i | input | LIM_W | Upper gap limit in ticks |
| need_i | input | NEED_W | Required number of passing gaps |
| poll_i | input | 1 | Return-to-polling command |
| mode_o | output | 2 | Mode: 0 sleep, 1 startup, 2 bitcheck, 3 receiving |
| pass_o | output | 1 | High while in receiving mode |
| fail_o | output | 1 | High after a failed check until the next valid start |
| cnt_o | output | LIM_W | Interval counter |

## Verification
A wrong armed flag or a wrong passing-gap count leaves no trace at the ports until a gap closes. It then shows as a fail where a pass was due, or as receiving mode one gap early or late, and the per-tick comparison of `mode_o` catches that on the tick of that edge. A counter that slips by one appears on `cnt_o` on the very next tick. It also moves the timeout tick, so `mode_o` and `fail_o` differ from the prediction one tick early or late. A start or poll that leaks into the wrong mode changes `mode_o` on the next clock, and the check right after that pulse exposes it.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
   typedef enum logic [1:0] {
      BM_SLEEP   = 2'd0,
      BM_STARTUP = 2'd1,
      BM_CHECK   = 2'd2,
      BM_RECV    = 2'd3
   } bmode_t;
endpackage

// File: rtl/bchk_startup.sv
module bchk_startup #(
   parameter int ST_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int SC_W = (ST_TICKS > 1) ? $clog2(ST_TICKS) : 1;

   generate
      if (ST_TICKS == 1) begin : g_single
         assign done_o = run_i & tick_i;
      end else begin : g_count
         localparam logic [SC_W-1:0] LAST = SC_W'(ST_TICKS - 1);
         logic [SC_W-1:0] sc_q;
         assign done_o = run_i & tick_i & (sc_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              sc_q <= '0;
            else if (!run_i)         sc_q <= '0;
            else if (done_o)         sc_q <= '0;
            else if (tick_i)         sc_q <= sc_q + 1'b1;
         end
         // R3
         sc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sc_q <= LAST);
      end
   endgenerate
endmodule

// File: rtl/bchk_interval.sv
module bchk_interval #(
   parameter int LIM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             dem_i,
   input  logic             run_i,
   input  logic             kill_i,
   input  logic [LIM_W-1:0] hi_i,
   output logic             edge_o,
   output logic [LIM_W-1:0] cnt_o
);
   logic dem_q;

   assign edge_o = tick_i & (dem_i != dem_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dem_q <= 1'b0;
      else if (tick_i)  dem_q <= dem_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_o <= '0;
      else if (!run_i || kill_i) cnt_o <= '0;
      else if (edge_o)           cnt_o <= LIM_W'(1);
      else if (tick_i)           cnt_o <= cnt_o + 1'b1;
   end

   // R6
   cnt_below_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_o < hi_i));
endmodule

// File: rtl/bchk_ctrl.sv
module bchk_ctrl
   import bchk_pkg::*;
#(
   parameter int LIM_W  = 8,
   parameter int NEED_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              poll_i,
   input  logic              tick_i,
   input  logic              edge_i,
   input  logic [LIM_W-1:0]  cnt_i,
   input  logic              st_done_i,
   input  logic [LIM_W-1:0]  lo_i,
   input  logic [LIM_W-1:0]  hi_i,
   input  logic [NEED_W-1:0] need_i,
   output bmode_t            mode_o,
   output logic              fail_o,
   output logic [LIM_W-1:0]  hi_q_o,
   output logic              kill_o
);
   bmode_t            mode_q, mode_d;
   logic              fail_q, fail_d;
   logic              armed_q, armed_d;
   logic [NEED_W-1:0] good_q, good_d;
   logic [LIM_W-1:0]  lo_q, hi_q;
   logic [NEED_W-1:0] need_q;
   logic              latch;
   logic              bad;
   logic [NEED_W:0]   need_eff;
   logic [NEED_W:0]   good_inc;
   logic [LIM_W:0]    cnt_inc;

   assign need_eff = (need_q == '0) ? (NEED_W+1)'(1) : {1'b0, need_q};
   assign good_inc = {1'b0, good_q} + 1'b1;
   assign cnt_inc  = {1'b0, cnt_i} + 1'b1;

   always_comb begin
      mode_d  = mode_q;
      fail_d  = fail_q;
      armed_d = armed_q;
      good_d  = good_q;
      latch   = 1'b0;
      bad     = 1'b0;
      kill_o  = 1'b0;
      unique case (mode_q)
         BM_SLEEP: begin
            if (start_i) begin
               latch = 1'b1;
               if (lo_i >= hi_i) fail_d = 1'b1;
               else begin
                  fail_d = 1'b0;
                  mode_d = BM_STARTUP;
               end
            end
         end
         BM_STARTUP: begin
            if (st_done_i) begin
               mode_d  = BM_CHECK;
               armed_d = 1'b0;
               good_d  = '0;
            end
         end
         BM_CHECK: begin
            if (edge_i) begin
               if (!armed_q)          armed_d = 1'b1;
               else if (cnt_i < lo_q) bad = 1'b1;
               else if (good_inc == need_eff) begin
                  mode_d = BM_RECV;
                  kill_o = 1'b1;
               end else good_d = good_inc[NEED_W-1:0];
            end else if (tick_i && (cnt_inc == {1'b0, hi_q})) begin
               bad = 1'b1;
            end
            if (bad) begin
               mode_d = BM_SLEEP;
               fail_d = 1'b1;
               kill_o = 1'b1;
            end
         end
         BM_RECV: begin
            if (poll_i) mode_d = BM_SLEEP;
         end
         default: mode_d = BM_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= BM_SLEEP;
         fail_q  <= 1'b0;
         armed_q <= 1'b0;
         good_q  <= '0;
         lo_q    <= '0;
         hi_q    <= LIM_W'(1);
         need_q  <= '0;
      end else begin
         mode_q  <= mode_d;
         fail_q  <= fail_d;
         armed_q <= armed_d;
         good_q  <= good_d;
         if (latch) begin
            lo_q   <= lo_i;
            hi_q   <= hi_i;
            need_q <= need_i;
         end
      end
   end

   assign mode_o = mode_q;
   assign fail_o = fail_q;
   assign hi_q_o = hi_q;

   // R9
   recv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BM_RECV && !poll_i) |=> (mode_q == BM_RECV));
   // R5
   fail_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> (mode_q == BM_SLEEP));
   // R2
   sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BM_SLEEP && !start_i) |=> (mode_q == BM_SLEEP));
   // R8
   good_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BM_CHECK) |-> ({1'b0, good_q} < need_eff));
   // R10
   lim_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BM_STARTUP) |-> (lo_q < hi_q));
endmodule

// File: rtl/bchk_seq.sv
module bchk_seq
   import bchk_pkg::*;
#(
   parameter int LIM_W         = 8,
   parameter int NEED_W        = 4,
   parameter int STARTUP_TICKS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              dem_i,
   input  logic              start_i,
   input  logic [LIM_W-1:0]  lim_lo_i,
   input  logic [LIM_W-1:0]  lim_hi_i,
   input  logic [NEED_W-1:0] need_i,
   input  logic              poll_i,
   output logic [1:0]        mode_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [LIM_W-1:0]  cnt_o
);
   generate
      if (LIM_W < 2 || LIM_W > 16) begin : g_bad_lim
         $error("bchk_seq: LIM_W must lie in 2..16");
      end
      if (NEED_W < 1 || NEED_W > 8) begin : g_bad_need
         $error("bchk_seq: NEED_W must lie in 1..8");
      end
      if (STARTUP_TICKS < 1) begin : g_bad_st
         $error("bchk_seq: STARTUP_TICKS must be at least 1");
      end
   endgenerate

   bmode_t           mode;
   logic             st_done;
   logic             edge_w;
   logic             kill;
   logic [LIM_W-1:0] hi_q;
   logic [LIM_W-1:0] cnt;

   bchk_startup #(.ST_TICKS(STARTUP_TICKS)) u_startup (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (mode == BM_STARTUP),
      .tick_i (tick_i),
      .done_o (st_done)
   );

   bchk_interval #(.LIM_W(LIM_W)) u_interval (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .dem_i  (dem_i),
      .run_i  (mode == BM_CHECK),
      .kill_i (kill),
      .hi_i   (hi_q),
      .edge_o (edge_w),
      .cnt_o  (cnt)
   );

   bchk_ctrl #(.LIM_W(LIM_W), .NEED_W(NEED_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .poll_i    (poll_i),
      .tick_i    (tick_i),
      .edge_i    (edge_w & (mode == BM_CHECK)),
      .cnt_i     (cnt),
      .st_done_i (st_done),
      .lo_i      (lim_lo_i),
      .hi_i      (lim_hi_i),
      .need_i    (need_i),
      .mode_o    (mode),
      .fail_o    (fail_o),
      .hi_q_o    (hi_q),
      .kill_o    (kill)
   );

   assign mode_o = mode;
   assign pass_o = (mode == BM_RECV);
   assign cnt_o  = cnt;

   // R1
   idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != BM_CHECK) |-> (cnt == '0));
   // R3
   check_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BM_STARTUP && !st_done) |=> (mode == BM_STARTUP));
endmodule

// File: tb/bchk_seq_test.sv
module bchk_seq_test;
   localparam int LW = 8;
   localparam int NW = 4;
   localparam int ST = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0, dem_i = 1'b0, start_i = 1'b0, poll_i = 1'b0;
   logic [LW-1:0] lim_lo_i = '0, lim_hi_i = '0;
   logic [NW-1:0] need_i = '0;
   logic [1:0]    mode_o;
   logic          pass_o, fail_o;
   logic [LW-1:0] cnt_o;

   bchk_seq #(.LIM_W(LW), .NEED_W(NW), .STARTUP_TICKS(ST)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dem_i(dem_i),
      .start_i(start_i), .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i),
      .need_i(need_i), .poll_i(poll_i), .mode_o(mode_o), .pass_o(pass_o),
      .fail_o(fail_o), .cnt_o(cnt_o));

   always #10 clk = ~clk;

   int ncmp = 0, nerr = 0;
   bit finished = 0;

   // reference state, built from the requirements
   int m_mode = 0, m_cnt = 0, m_sc = 0, m_good = 0;
   int m_lo = 0, m_hi = 1, m_need = 0;
   bit m_armed = 0, m_fail = 0, m_prev = 0;
   bit lvl = 0;

   function automatic int need_eff(int n);
      return (n == 0) ? 1 : n;
   endfunction

   task automatic cmp(input string tag, input int act, input int exp, input string what);
      ncmp++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic chk(input string tag);
      cmp(tag, mode_o, m_mode, "mode");
      cmp(tag, cnt_o, m_cnt, "cnt");
      cmp(tag, pass_o, (m_mode == 3), "pass");
      cmp(tag, fail_o, m_fail, "fail");
   endtask

   task automatic go_fail();
      m_mode = 0; m_cnt = 0; m_fail = 1;
   endtask

   task automatic do_tick(input bit d, input string tag);
      bit e;
      dem_i = d; tick_i = 1'b1;
      @(posedge clk);
      e = (d != m_prev);
      m_prev = d;
      case (m_mode)
         1: begin
            m_sc++;
            if (m_sc == ST) begin
               m_mode = 2; m_cnt = 0; m_armed = 0; m_good = 0;
            end
         end
         2: begin
            if (e) begin
               if (!m_armed) begin m_armed = 1; m_cnt = 1; end
               else if (m_cnt < m_lo) go_fail();
               else begin
                  m_good++;
                  if (m_good == need_eff(m_need)) begin m_mode = 3; m_cnt = 0; end
                  else m_cnt = 1;
               end
            end else begin
               m_cnt++;
               if (m_cnt == m_hi) go_fail();
            end
         end
         default: ;
      endcase
      @(negedge clk);
      tick_i = 1'b0;
      chk(tag);
   endtask

   task automatic do_start(input int lo, input int hi, input int nd, input string tag);
      lim_lo_i = LW'(lo); lim_hi_i = LW'(hi); need_i = NW'(nd); start_i = 1'b1;
      @(posedge clk);
      if (m_mode == 0) begin
         m_lo = lo; m_hi = hi; m_need = nd;
         if (lo >= hi) m_fail = 1;
         else begin m_fail = 0; m_mode = 1; m_sc = 0; end
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(tag);
   endtask

   task automatic do_poll(input string tag);
      poll_i = 1'b1;
      @(posedge clk);
      if (m_mode == 3) m_mode = 0;
      @(negedge clk);
      poll_i = 1'b0;
      chk(tag);
   endtask

   task automatic run_startup();
      for (int i = 0; i < ST; i++) do_tick(lvl, "R3");
   endtask

   // one gap of L ticks: L-1 steady ticks, then the toggling tick
   task automatic gap(input int L, input string tag);
      for (int i = 1; i < L; i++) if (m_mode == 2) do_tick(lvl, tag);
      if (m_mode == 2) begin lvl = ~lvl; do_tick(lvl, tag); end
   endtask

   initial begin
      #(64'd20 * 64'd150000);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1");

      // tick and poll in sleep leave the block asleep
      do_tick(1'b0, "R2");
      do_poll("R9");

      // pass path: window [4,8), three gaps; first edge arrives right away
      do_start(4, 8, 3, "R2");
      do_start(1, 2, 1, "R2");          // ignored during startup
      run_startup();
      lvl = ~lvl; do_tick(lvl, "R7");   // arming edge at cnt 0
      gap(5, "R4"); gap(4, "R8"); gap(7, "R8");
      do_start(4, 8, 3, "R2");          // ignored while receiving
      do_tick(lvl, "R9"); do_tick(~lvl, "R9");
      lvl = ~lvl;
      do_poll("R9");

      // short gap fails on its closing edge
      do_start(5, 9, 2, "R2");
      run_startup();
      gap(2, "R7");
      gap(4, "R5");
      do_tick(lvl, "R11"); do_tick(~lvl, "R11");
      lvl = ~lvl;

      // no edge: timeout at the upper limit
      do_start(3, 6, 2, "R11");
      run_startup();
      gap(1, "R7");
      gap(20, "R6");

      // timeout before any edge
      do_start(2, 5, 1, "R2");
      run_startup();
      for (int i = 0; i < 6; i++) if (m_mode == 2) do_tick(lvl, "R6");

      // inverted and equal limits
      do_start(9, 9, 2, "R10");
      do_tick(lvl, "R10");
      do_start(12, 3, 2, "R10");

      // required count 0 acts as 1
      do_start(2, 10, 0, "R8");
      run_startup();
      gap(3, "R7"); gap(2, "R8");
      do_poll("R9");

      // random trials
      for (int t = 0; t < 30; t++) begin
         int lo, hi, nd;
         lo = 2 + $urandom_range(8);
         hi = lo + 1 + $urandom_range(11);
         nd = $urandom_range(5);
         do_start(lo, hi, nd, "R2");
         for (int i = 0; i < ST; i++) begin
            repeat ($urandom_range(2)) @(posedge clk);
            @(negedge clk);
            do_tick(lvl, "R3");
         end
         for (int g = 0; g < 20 && m_mode == 2; g++) begin
            int L;
            if ($urandom_range(3) != 0) L = lo + $urandom_range(hi - 1 - lo);
            else L = 1 + $urandom_range(hi + 1);
            gap(L, "R4");
         end
         if (m_mode == 2) gap(hi + 2, "R6");
         if (m_mode == 3) do_poll("R9");
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
   end
endmodule